// File: doc/BRIEF.md
# Microcoded Instruction Dispatch Sequencer

This block drives a microprogrammed controller. It reads a 10-bit instruction word and walks through a microcode store. On every clock it outputs the control field of the current micro-word, the two operand select codes and the current microcode address. Micro-words run in a chain through their next-address fields. When a micro-word has its reload bit set, the block samples the instruction and looks its 4-bit opcode up in a 16-entry dispatch table. It then jumps to one of four start addresses for that opcode. Two condition bits pick the start address. Each opcode chooses which condition set produces those bits.

Both tables are constant contents computed inside the block. The dispatch table entry for opcode k holds two operand-enable bits, a condition-set select and four 7-bit start addresses. The microcode store holds 96 words of 40 bits. A 7-bit microcode address leaves codes 96 to 127 unused. A jump to any of them is reported and sent back to the fetch word.

Top module: `ucode_dispatch`

## Requirements
- R1: While reset is held, and on the first cycle after it, the microcode address is 0, the error flag is 0 and both operand selects are 0.
- R2: Micro-word 0 is the only word with its reload bit set. On a reload step the instruction is sampled, and the address moves to start[p] of opcode k = instruction bits 9..6. The start addresses are start[p] = ((4k+p) mod 11)*8+1, with three exceptions. For even k with bit 2 of k set, start[1] and start[3] repeat start[0]. For k=13, start[3] is 100.
- R3: On a step without reload, the address moves to the word's next field and the latched operand fields are unchanged. For address a, the next field is a+1, or 0 when a mod 8 = 7.
- R4: An opcode with bit 0 clear uses the default condition set: p = {jump status input, NOT(AND of instruction bits 2..0)}.
- R5: An opcode with bit 0 set uses the alternative condition set: p = instruction bits 1..0. The jump status input is ignored.
- R6: The instruction words 0x000 and 0x3FF act as no-operation: a reload with either one returns the address to 0 without an error.
- R7: A target address of 96 or above is never entered. The address goes to 0, and the error output is 1 for the cycle that follows that step only.
- R8: Operand select A equals latched instruction bits 5..3 when bit 0 of the address is 1 and the opcode enables A (k[3]=0 or k[2]=1); otherwise it is 0. Operand select B equals latched bits 2..0 when bit 1 of the address is 1 and the opcode enables B (k[1] or k[0] is 1); otherwise it is 0.
- R9: Bit i of the 30-bit control output equals bit (i mod 7) of the current microcode address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_i | input | 10 | Instruction word, sampled on reload steps |
| jmp_ok_i | input | 1 | Evaluated jump status, used by the default condition set |
| ctrl_o | output | 30 | Control field of the current micro-word |
| opsel_a_o | output | 3 | Operand select code A |
| opsel_b_o | output | 3 | Operand select code B |
| upc_o | output | 7 | Current microcode address |
| err_o | output | 1 | Pulses after an out-of-range target was rejected |

## Verification
The bench builds the block with its default sizes: a 7-bit address over a 96-word store. That leaves 32 unused codes, so the illegal target of opcode 13 path 3 can actually be reached and the error path is exercised. Random instructions arrive every cycle but are only sampled at fetch. This checks that the latch holds between reloads, and it drives every opcode through both condition sets and into every micro-word reached from the dispatch table. Directed reloads fix the repeated-path, no-operation, illegal-target and operand-gating cases to known addresses.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int IW       = 10;
    localparam int OPC_W    = 4;
    localparam int FLD_W    = 3;
    localparam int NFLD     = 2;
    localparam int UAW      = 7;
    localparam int UDEPTH   = 96;
    localparam int UW       = 40;
    localparam int NPATH    = 4;
    localparam int PATH_W   = $clog2(NPATH);
    localparam int CTRL_W   = UW - 1 - NFLD - UAW;
    localparam int NOPC     = 1 << OPC_W;
    localparam int SEG_LEN  = 8;
    localparam int SEG_MOD  = 11;
    localparam int BAD_OPC  = 13;
    localparam int BAD_TGT  = 100;

    typedef logic [UAW-1:0] uaddr_t;

    // 40-bit micro-word: reload flag, operand routing, next address, control
    typedef struct packed {
        logic              reload;
        logic [NFLD-1:0]   route;   // [1] routes field A, [0] routes field B
        uaddr_t            nxt;
        logic [CTRL_W-1:0] ctrl;
    } uword_t;

    // dispatch table entry
    typedef struct packed {
        logic [NFLD-1:0]             opnd_en; // [1] field A, [0] field B
        logic                        alt_set;
        logic [NPATH-1:0][UAW-1:0]   start;
    } imap_t;

    function automatic imap_t map_entry(input logic [OPC_W-1:0] k);
        imap_t e;
        e.opnd_en = {(~k[3]) | k[2], k[1] | k[0]};
        e.alt_set = k[0];
        for (int p = 0; p < NPATH; p++) begin
            e.start[p] = uaddr_t'((((int'(k) * NPATH + p) % SEG_MOD) * SEG_LEN) + 1);
        end
        if (k[2] && !k[0]) begin
            e.start[1] = e.start[0];
            e.start[3] = e.start[0];
        end
        if (int'(k) == BAD_OPC) begin
            e.start[3] = uaddr_t'(BAD_TGT);
        end
        return e;
    endfunction

    function automatic uword_t uword_at(input uaddr_t a);
        uword_t w;
        w.reload = (a == '0);
        w.route  = {a[0], a[1]};
        if (a == '0 || (int'(a) % SEG_LEN) == SEG_LEN - 1) begin
            w.nxt = '0;
        end else begin
            w.nxt = a + uaddr_t'(1);
        end
        for (int i = 0; i < CTRL_W; i++) begin
            w.ctrl[i] = a[i % UAW];
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_imap.sv
module useq_imap
    import useq_pkg::*;
(
    input  logic [IW-1:0]   ir,
    input  logic            jmp_ok,
    output uaddr_t          target,
    output logic [NFLD-1:0] opnd_en
);

    imap_t                tbl [NOPC];
    imap_t                ent;
    logic [PATH_W-1:0]    path;
    logic                 is_nop;

    for (genvar g = 0; g < NOPC; g++) begin : g_map
        assign tbl[g] = map_entry(OPC_W'(g));
    end

    always_comb begin
        ent    = tbl[ir[IW-1 -: OPC_W]];
        is_nop = (ir == '0) || (&ir);
        if (ent.alt_set) begin
            path = ir[PATH_W-1:0];
        end else begin
            path = {jmp_ok, ~(&ir[FLD_W-1:0])};
        end
        target  = is_nop ? '0 : ent.start[path];
        opnd_en = ent.opnd_en;
    end

endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);

    uword_t tbl [UDEPTH];

    for (genvar g = 0; g < UDEPTH; g++) begin : g_word
        assign tbl[g] = uword_at(uaddr_t'(g));
    end

    always_comb begin
        if (int'(addr) < UDEPTH) begin
            word = tbl[addr];
        end else begin
            word = '0;
        end
    end

endmodule

// File: rtl/useq_oproute.sv
module useq_oproute
    import useq_pkg::*;
(
    input  logic [NFLD*FLD_W-1:0]          opnd,
    input  logic [NFLD-1:0]                en,
    input  logic [NFLD-1:0]                route,
    output logic [NFLD-1:0][FLD_W-1:0]     sel
);

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign sel[f] = (en[f] && route[f]) ? opnd[f*FLD_W +: FLD_W] : '0;
    end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     ir_i,
    input  logic              jmp_ok_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [FLD_W-1:0]  opsel_a_o,
    output logic [FLD_W-1:0]  opsel_b_o,
    output logic [UAW-1:0]    upc_o,
    output logic              err_o
);

    typedef struct packed {
        uaddr_t                   upc;
        logic [NFLD*FLD_W-1:0]    opnd;
        logic [NFLD-1:0]          en;
        logic                     err;
    } state_t;

    state_t                      st_d, st_q;
    uword_t                      cur_w;
    uaddr_t                      map_tgt;
    uaddr_t                      tgt;
    logic [NFLD-1:0]             map_en;
    logic [NFLD-1:0][FLD_W-1:0]  sel;

    logic                        w_reload;
    uaddr_t                      w_nxt;
    logic [NFLD-1:0]             w_route;

    useq_store u_store (
        .addr (st_q.upc),
        .word (cur_w)
    );

    useq_imap u_imap (
        .ir      (ir_i),
        .jmp_ok  (jmp_ok_i),
        .target  (map_tgt),
        .opnd_en (map_en)
    );

    useq_oproute u_route (
        .opnd  (st_q.opnd),
        .en    (st_q.en),
        .route (cur_w.route),
        .sel   (sel)
    );

    assign w_reload = cur_w.reload;
    assign w_nxt    = cur_w.nxt;
    assign w_route  = cur_w.route;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        tgt      = cur_w.reload ? map_tgt : cur_w.nxt;
        if (cur_w.reload) begin
            st_d.opnd = ir_i[NFLD*FLD_W-1:0];
            st_d.en   = map_en;
        end
        if (int'(tgt) >= UDEPTH) begin
            st_d.upc = '0;
            st_d.err = 1'b1;
        end else begin
            st_d.upc = tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o    = cur_w.ctrl;
    assign opsel_a_o = sel[1];
    assign opsel_b_o = sel[0];
    assign upc_o     = st_q.upc;
    assign err_o     = st_q.err;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [IW-1:0]           ir_i,
    input logic [UAW-1:0]          upc_o,
    input logic                    err_o,
    input logic [FLD_W-1:0]        opsel_a_o,
    input logic [FLD_W-1:0]        opsel_b_o,
    input logic                    w_reload,
    input logic [UAW-1:0]          w_nxt,
    input logic [NFLD-1:0]         w_route,
    input logic [NFLD*FLD_W-1:0]   opnd_q
);

    AST_UPC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(upc_o) < UDEPTH); // R7

    AST_ERR_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (upc_o == '0)); // R7

    AST_STEP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !w_reload |=> (err_o || upc_o == $past(w_nxt))); // R3

    AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !w_reload |=> $stable(opnd_q)); // R3

    AST_NOP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (w_reload && (ir_i == '0 || (&ir_i))) |=> (upc_o == '0 && !err_o)); // R6

    AST_SEL_A_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !w_route[1] |-> (opsel_a_o == '0)); // R8

    AST_SEL_B_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !w_route[0] |-> (opsel_b_o == '0)); // R8

endmodule

bind ucode_dispatch useq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_i      (ir_i),
    .upc_o     (upc_o),
    .err_o     (err_o),
    .opsel_a_o (opsel_a_o),
    .opsel_b_o (opsel_b_o),
    .w_reload  (w_reload),
    .w_nxt     (w_nxt),
    .w_route   (w_route),
    .opnd_q    (st_q.opnd)
);

// File: tb/tb_ucode_dispatch.sv
module tb_ucode_dispatch;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  ir_i;
    logic        jmp_ok_i;
    logic [29:0] ctrl_o;
    logic [2:0]  opsel_a_o;
    logic [2:0]  opsel_b_o;
    logic [6:0]  upc_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int         m_upc;
    logic [5:0] m_opnd;
    logic [1:0] m_en;
    bit         m_err;

    always #10 clk = ~clk;

    ucode_dispatch dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_i      (ir_i),
        .jmp_ok_i  (jmp_ok_i),
        .ctrl_o    (ctrl_o),
        .opsel_a_o (opsel_a_o),
        .opsel_b_o (opsel_b_o),
        .upc_o     (upc_o),
        .err_o     (err_o)
    );

    function automatic int ref_start(input int k, input int p);
        int q = p;
        if (k == 13 && p == 3) return 100;
        if ((k & 4) != 0 && (k & 1) == 0 && (p & 1) != 0) q = 0;
        return (((4 * k + q) % 11) * 8) + 1;
    endfunction

    function automatic int ref_next(input int a);
        if (a == 0 || a % 8 == 7) return 0;
        return a + 1;
    endfunction

    function automatic logic [29:0] ref_ctrl(input int a);
        logic [29:0] c;
        for (int i = 0; i < 30; i++) c[i] = (a >> (i % 7)) & 1;
        return c;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outs();
        int ea = 0;
        int eb = 0;
        if ((m_upc & 1) != 0 && m_en[1]) ea = int'(m_opnd[5:3]);
        if ((m_upc & 2) != 0 && m_en[0]) eb = int'(m_opnd[2:0]);
        chk("R2 R3", "upc", int'(upc_o), m_upc);
        chk("R7", "err", int'(err_o), int'(m_err));
        chk("R8", "opsel_a", int'(opsel_a_o), ea);
        chk("R8", "opsel_b", int'(opsel_b_o), eb);
        chk("R9", "ctrl", int'(ctrl_o), int'(ref_ctrl(m_upc)));
    endtask

    task automatic step(input logic [9:0] ir, input logic jmp);
        int tgt;
        int k;
        int p;
        ir_i     = ir;
        jmp_ok_i = jmp;
        if (m_upc == 0) begin
            k      = int'(ir[9:6]);
            m_opnd = ir[5:0];
            m_en   = {((k & 8) == 0) || ((k & 4) != 0), (k & 3) != 0};
            if ((k & 1) != 0) p = int'(ir[1:0]);
            else              p = (int'(jmp) << 1) | int'(ir[2:0] != 3'b111);
            if (ir == 10'h000 || ir == 10'h3FF) tgt = 0;
            else                                tgt = ref_start(k, p);
        end else begin
            tgt = ref_next(m_upc);
        end
        if (tgt >= 96) begin
            m_upc = 0;
            m_err = 1'b1;
        end else begin
            m_upc = tgt;
            m_err = 1'b0;
        end
        @(posedge clk);
        #5;
        check_outs();
    endtask

    task automatic to_fetch();
        while (m_upc != 0) step(10'h155, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] r;
        void'($urandom(32'h1A2B_3C4D));
        rst_n    = 1'b0;
        ir_i     = 10'h0EE;
        jmp_ok_i = 1'b0;
        m_upc = 0; m_opnd = '0; m_en = '0; m_err = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "upc in reset", int'(upc_o), 0);
        chk("R1", "err in reset", int'(err_o), 0);
        chk("R1", "opsel_a in reset", int'(opsel_a_o), 0);
        chk("R1", "opsel_b in reset", int'(opsel_b_o), 0);
        rst_n = 1'b1;

        // R4: opcode 2, default set, bits 2..0 = 111 so low path bit is 0
        step(10'h087, 1'b1);
        chk("R4", "default set jmp=1", int'(upc_o), 81);
        to_fetch();
        step(10'h087, 1'b0);
        chk("R4", "default set jmp=0", int'(upc_o), 65);
        to_fetch();
        // R5: opcode 5, alternative set, path from bits 1..0
        step(10'h142, 1'b1);
        chk("R5", "alt set path 2", int'(upc_o), 1);
        to_fetch();
        step(10'h141, 1'b0);
        chk("R5", "alt set path 1", int'(upc_o), 81);
        to_fetch();
        // R2: opcode 4 path 1 repeats path 0
        step(10'h100, 1'b0);
        chk("R2", "repeated path", int'(upc_o), 41);
        to_fetch();
        // R6: no-operation words
        step(10'h000, 1'b1);
        chk("R6", "all-zero word", int'(upc_o), 0);
        chk("R6", "all-zero no err", int'(err_o), 0);
        step(10'h3FF, 1'b1);
        chk("R6", "all-one word", int'(upc_o), 0);
        chk("R6", "all-one no err", int'(err_o), 0);
        // R7: opcode 13 path 3 targets 100
        step(10'h343, 1'b0);
        chk("R7", "illegal target home", int'(upc_o), 0);
        chk("R7", "illegal target err", int'(err_o), 1);
        step(10'h000, 1'b0);
        chk("R7", "err is a pulse", int'(err_o), 0);
        // R8: opcode 3 enables both fields, A=5 B=6, lands at 25
        step(10'h0EE, 1'b0);
        chk("R8", "sel A routed", int'(opsel_a_o), 5);
        chk("R8", "sel B unrouted", int'(opsel_b_o), 0);
        step(10'h2AA, 1'b1);
        chk("R3", "held field A", int'(opsel_a_o), 0);
        chk("R3", "held field B", int'(opsel_b_o), 6);
        to_fetch();
        // R8: opcode 8 disables both fields
        step(10'h22E, 1'b0);
        chk("R8", "disabled field A", int'(opsel_a_o), 0);
        chk("R9", "ctrl at word 1", int'(ctrl_o), int'(ref_ctrl(1)));

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int sel = int'($urandom_range(0, 9));
            r = 10'($urandom_range(0, 1023));
            if (sel == 0) r = 10'h000;
            else if (sel == 1) r = 10'h3FF;
            else if (sel == 2) r = {4'd13, r[5:2], 2'b11};
            step(r, 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule